// File: doc/BRIEF.md
# JTAG Virtual TAP Multiplexer

This block lets one physical JTAG port serve several on-chip debug cores at once. It sits behind three user-defined scan instructions of the device TAP. The TAP controller turns those instructions into select lines and passes on its capture, shift and update strobes. One chain holds a 16-bit core address. A second chain shifts the private 8-bit instruction register of the addressed core. A third chain shifts that core's private data register. Each core therefore behaves as if it had a TAP of its own, and no core claims a user instruction for itself.

Address 0 is an enumeration responder. Its data register reports how many cores are attached and then the 32-bit identifier of each core. Host software uses it to find the cores. Addresses 1 to NCORES reach the cores in ascending order. Any higher address selects a one-bit bypass stage.

Top module: `vtap_mux`

## Requirements
- R1: After reset the address register is 0, every virtual instruction register holds 0, and tdo is 0.
- R2: The address chain is 16 bits long and shifts LSB first. Capture loads the address currently in use. The address in use changes only on an update of the address chain, so a scan with no update leaves it unchanged.
- R3: For addresses 0 to NCORES, the instruction chain is 8 bits long, shifts LSB first and captures 8'h01. An update writes the shifted value into the addressed core's core_ir field (core k-1 at bits [8k-1:8(k-1)]). The fields of the other cores do not change.
- R4: For an address k from 1 to NCORES, tdo during a data-chain scan equals core_tdo[k-1], and core_tdi always follows tdi.
- R5: core_capture, core_shift and core_update are asserted only for the addressed core, only while the data chain is selected, and never while address 0 or an unpopulated address is selected.
- R6: At address 0, the data chain captures the core count (16 bits), followed by each core_id word from core 0 upward (core k at bits [32k+31:32k]). It shifts out LSB first, 16+32*NCORES bits in total.
- R7: For an address above NCORES, both the instruction chain and the data chain are a 1-bit bypass stage that captures 0. No core_ir field changes at such an address.
- R8: Scans on the instruction or data chain leave the address unchanged. Scans on the address chain leave every core_ir field unchanged.
- R9: While no chain is selected, tdo is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | JTAG test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_addr | input | 1 | Address chain instruction active |
| sel_ir | input | 1 | Virtual instruction chain active |
| sel_dr | input | 1 | Virtual data chain active |
| capture | input | 1 | Capture-DR state of the device TAP |
| shift | input | 1 | Shift-DR state of the device TAP |
| update | input | 1 | Update-DR state of the device TAP |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out of the selected chain |
| cur_addr | output | 16 | Core address in use |
| core_ir | output | 8*NCORES | Virtual instruction register of each core |
| core_capture | output | NCORES | Per-core data capture strobe |
| core_shift | output | NCORES | Per-core data shift strobe |
| core_update | output | NCORES | Per-core data update strobe |
| core_tdi | output | 1 | Serial data toward the cores |
| core_tdo | input | NCORES | Serial data from each core |
| core_id | input | 32*NCORES | Identifier word of each core |

## Verification
The bench scans the address chain once without an update, because a design that committed the address while shifting would move cur_addr at that point. It checks that an instruction update lands only in the addressed core's field, which catches an off-by-one between address and core index. It reads the full enumeration register and compares the order of the count and the identifiers, so a design with swapped words or MSB-first shifting would fail. At an unpopulated address it checks the one-cycle bypass delay and that the core strobes stay low, since a design that decoded such an address to a real core would forward strobes or data there.

// File: rtl/vtap_mux.sv
module vtap_mux #(
  parameter int NCORES = 3,
  parameter int AW = 16,
  parameter int IRW = 8,
  parameter int IDW = 32,
  parameter logic [IRW-1:0] IR_CAPTURE = 1
) (
  input  logic                    tck,
  input  logic                    rst_n,
  input  logic                    sel_addr,
  input  logic                    sel_ir,
  input  logic                    sel_dr,
  input  logic                    capture,
  input  logic                    shift,
  input  logic                    update,
  input  logic                    tdi,
  output logic                    tdo,
  output logic [AW-1:0]           cur_addr,
  output logic [NCORES*IRW-1:0]   core_ir,
  output logic [NCORES-1:0]       core_capture,
  output logic [NCORES-1:0]       core_shift,
  output logic [NCORES-1:0]       core_update,
  output logic                    core_tdi,
  input  logic [NCORES-1:0]       core_tdo,
  input  logic [NCORES*IDW-1:0]   core_id
);
  localparam int EW = AW + NCORES * IDW;
  localparam logic [AW-1:0] NC = AW'(NCORES);

  logic [AW-1:0]     addr_sr, addr_q;
  logic [IRW-1:0]    ir_sr;
  logic [EW-1:0]     enum_sr;
  logic              byp;
  logic [NCORES-1:0] hit;

  wire is_enum = addr_q == '0;
  wire live    = addr_q <= NC;
  wire any_sel = sel_ir | sel_dr;

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n) begin
      addr_sr <= '0;
      addr_q  <= '0;
    end else if (sel_addr) begin
      if (capture)     addr_sr <= addr_q;
      else if (shift)  addr_sr <= {tdi, addr_sr[AW-1:1]};
      else if (update) addr_q  <= addr_sr;
    end

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n)                  ir_sr <= '0;
    else if (sel_ir && live) begin
      if (capture)    ir_sr <= IR_CAPTURE;
      else if (shift) ir_sr <= {tdi, ir_sr[IRW-1:1]};
    end

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n)                           enum_sr <= '0;
    else if (sel_dr && is_enum) begin
      if (capture)    enum_sr <= {core_id, NC};
      else if (shift) enum_sr <= {tdi, enum_sr[EW-1:1]};
    end

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n)                    byp <= 1'b0;
    else if (any_sel && !live) begin
      if (capture)    byp <= 1'b0;
      else if (shift) byp <= tdi;
    end

  for (genvar g = 0; g < NCORES; g++) begin : g_core
    logic [IRW-1:0] ir_q;
    assign hit[g] = addr_q == AW'(g + 1);
    always_ff @(posedge tck or negedge rst_n)
      if (!rst_n)                           ir_q <= '0;
      else if (sel_ir && update && hit[g])  ir_q <= ir_sr;
    assign core_ir[g*IRW +: IRW] = ir_q;
  end

  assign core_capture = {NCORES{sel_dr & capture}} & hit;
  assign core_shift   = {NCORES{sel_dr & shift}} & hit;
  assign core_update  = {NCORES{sel_dr & update}} & hit;
  assign core_tdi     = tdi;
  assign cur_addr     = addr_q;

  always_comb begin
    tdo = 1'b0;
    if (sel_addr)    tdo = addr_sr[0];
    else if (sel_ir) tdo = live ? ir_sr[0] : byp;
    else if (sel_dr) tdo = !live ? byp : is_enum ? enum_sr[0] : |(core_tdo & hit);
  end
endmodule

// File: rtl/vtap_mux_chk.sv
module vtap_mux_chk #(
  parameter int NCORES = 3,
  parameter int AW = 16,
  parameter int IRW = 8
) (
  input logic                  tck,
  input logic                  rst_n,
  input logic                  sel_addr,
  input logic                  sel_ir,
  input logic                  sel_dr,
  input logic                  capture,
  input logic                  shift,
  input logic                  update,
  input logic                  tdo,
  input logic [AW-1:0]         cur_addr,
  input logic [NCORES*IRW-1:0] core_ir,
  input logic [NCORES-1:0]     core_capture,
  input logic [NCORES-1:0]     core_shift,
  input logic [NCORES-1:0]     core_update
);
  localparam logic [AW-1:0] NC = AW'(NCORES);
  wire populated = cur_addr != '0 && cur_addr <= NC;

  a_r2_addr_commit: assert property (@(posedge tck) disable iff (!rst_n)
    cur_addr != $past(cur_addr) |-> $past(sel_addr && update));

  a_r3_ir_commit: assert property (@(posedge tck) disable iff (!rst_n)
    core_ir != $past(core_ir) |-> $past(sel_ir && update));

  a_r3_ir_capture: assert property (@(posedge tck) disable iff (!rst_n)
    (sel_ir && shift && $past(sel_ir && capture) && cur_addr <= NC) |-> tdo);

  a_r5_one_core: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0(core_shift) && $onehot0(core_capture) && $onehot0(core_update));

  a_r5_addressed: assert property (@(posedge tck) disable iff (!rst_n)
    (|{core_capture, core_shift, core_update}) |-> (sel_dr && populated));

  a_r7_bypass_zero: assert property (@(posedge tck) disable iff (!rst_n)
    (sel_dr && $past(sel_dr && capture) && cur_addr > NC) |-> !tdo);

  a_r9_idle_low: assert property (@(posedge tck) disable iff (!rst_n)
    !(sel_addr || sel_ir || sel_dr) |-> !tdo);
endmodule

bind vtap_mux vtap_mux_chk #(.NCORES(NCORES), .AW(AW), .IRW(IRW)) u_chk (
  .tck(tck), .rst_n(rst_n), .sel_addr(sel_addr), .sel_ir(sel_ir), .sel_dr(sel_dr),
  .capture(capture), .shift(shift), .update(update), .tdo(tdo),
  .cur_addr(cur_addr), .core_ir(core_ir), .core_capture(core_capture),
  .core_shift(core_shift), .core_update(core_update)
);

// File: tb/test_vtap_mux.sv
module test_vtap_mux;
  localparam int CLK = 10;
  localparam int N = 3;

  logic tck = 0, rst_n = 0;
  logic sel_addr = 0, sel_ir = 0, sel_dr = 0;
  logic capture = 0, shift = 0, update = 0, tdi = 0;
  logic tdo, core_tdi;
  logic [15:0] cur_addr;
  logic [N*8-1:0] core_ir;
  logic [N-1:0] core_capture, core_shift, core_update;
  logic [N-1:0] core_tdo = '0;
  logic [N*32-1:0] core_id = {32'hC0DE_0003, 32'hC0DE_0002, 32'hC0DE_0001};

  int total = 0, bad = 0;
  logic [255:0] sout;
  logic [N-1:0] cap_seen, shf_seen, upd_seen;
  bit tdi_bad;

  always #(CLK/2) tck = ~tck;

  vtap_mux i_vtap_mux (
    .tck(tck), .rst_n(rst_n), .sel_addr(sel_addr), .sel_ir(sel_ir), .sel_dr(sel_dr),
    .capture(capture), .shift(shift), .update(update), .tdi(tdi), .tdo(tdo),
    .cur_addr(cur_addr), .core_ir(core_ir), .core_capture(core_capture),
    .core_shift(core_shift), .core_update(core_update), .core_tdi(core_tdi),
    .core_tdo(core_tdo), .core_id(core_id)
  );

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_sel(input int ch, input logic v);
    sel_addr = (ch == 0) & v;
    sel_ir   = (ch == 1) & v;
    sel_dr   = (ch == 2) & v;
  endtask

  task automatic scan(input int ch, input int n, input logic [255:0] din, input bit upd);
    sout = '0; cap_seen = '0; shf_seen = '0; upd_seen = '0; tdi_bad = 0;
    @(negedge tck); set_sel(ch, 1); capture = 1;
    #1 cap_seen |= core_capture;
    @(negedge tck); capture = 0; shift = 1;
    for (int i = 0; i < n; i++) begin
      tdi = din[i];
      #1;
      sout[i] = tdo;
      shf_seen |= core_shift;
      if (core_tdi !== tdi) tdi_bad = 1;
      @(negedge tck);
    end
    shift = 0; update = upd;
    #1 upd_seen |= core_update;
    @(negedge tck); update = 0; set_sel(0, 0); tdi = 0;
  endtask

  task automatic t_reset;
    chk("R1 addr", 256'(cur_addr), 0);
    chk("R1 core_ir", 256'(core_ir), 0);
    #1 chk("R9 idle tdo", 256'(tdo), 0);
  endtask

  task automatic t_addr;
    scan(0, 16, 256'h0002, 1);
    chk("R2 capture old addr", sout, 0);
    chk("R2 addr committed", 256'(cur_addr), 2);
    scan(0, 16, 256'h0005, 0);
    chk("R2 capture current addr", sout, 2);
    chk("R2 no update keeps addr", 256'(cur_addr), 2);
    chk("R8 addr scan keeps core_ir", 256'(core_ir), 0);
  endtask

  task automatic t_ir;
    scan(1, 8, 256'hA5, 1);
    chk("R3 ir capture", sout, 256'h01);
    chk("R3 ir to core1", 256'(core_ir), 256'(24'h00A500));
    chk("R8 ir scan keeps addr", 256'(cur_addr), 2);
    scan(0, 16, 256'h0001, 1);
    scan(1, 8, 256'h3C, 1);
    chk("R3 ir to core0 only", 256'(core_ir), 256'(24'h00A53C));
  endtask

  task automatic t_dr;
    scan(0, 16, 256'h0003, 1);
    core_tdo = 3'b100;
    scan(2, 5, 256'h0A, 1);
    chk("R4 tdo from core2", sout, 256'h1F);
    chk("R4 core_tdi", 256'(tdi_bad), 0);
    chk("R5 strobes core2", 256'({cap_seen, shf_seen, upd_seen}), 256'(9'b100_100_100));
    core_tdo = 3'b011;
    scan(2, 5, 256'h15, 1);
    chk("R4 other cores masked", sout, 0);
    chk("R8 dr scan keeps addr", 256'(cur_addr), 3);
    core_tdo = '0;
  endtask

  task automatic t_enum;
    scan(0, 16, 256'h0000, 1);
    scan(2, 16 + 32*N, 256'h0, 1);
    chk("R6 enum content", sout, 256'({core_id, 16'd3}));
    chk("R5 no strobes at enum", 256'({cap_seen, shf_seen, upd_seen}), 0);
  endtask

  task automatic t_bypass;
    scan(0, 16, 256'h0007, 1);
    core_tdo = '1;
    scan(2, 4, 256'hB, 1);
    chk("R7 dr bypass", sout, 256'h6);
    chk("R5 no strobes unpopulated", 256'({cap_seen, shf_seen, upd_seen}), 0);
    scan(1, 4, 256'hB, 1);
    chk("R7 ir bypass", sout, 256'h6);
    chk("R7 core_ir unchanged", 256'(core_ir), 256'(24'h00A53C));
    core_tdo = '0;
    #1 chk("R9 idle tdo after scans", 256'(tdo), 0);
  endtask

  initial begin
    #(CLK*200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge tck);
    t_reset();
    rst_n = 1;
    @(negedge tck);
    t_addr();
    t_ir();
    t_dr();
    t_enum();
    t_bypass();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule